// File: doc/BRIEF.md
# Crystal and PLL Enable Control Registers

This block is the register-level controller for four clock sources of a chip: a main crystal oscillator, a slow crystal oscillator and two phase-locked loops. Software reaches it over a plain 32-bit bus that has an address, a write strobe, write data and combinational read data. Three registers are mapped: a crystal control word, a PLL control word and a PLL frequency word. From these the block drives one run request per clock source. It also drives the decoded multiplier and post-shift values that the analog PLL macros need.

The main crystal and the first PLL each have a software override bit. While the override is clear, hardware keeps the source running and the enable bit has no effect. Once the override is set, the enable bit decides. The second PLL has no override, so its enable bit switches it directly. The analog parts are not modelled here. Each of the main crystal and the two PLLs has a ready timer that stands in for start-up or lock time. A ready flag rises a parameterised number of cycles after its source starts to run, or one cycle later when the timer-enable bit for that group is clear. The flag drops one cycle after the source stops.

Top module: `osc_pll_ctrl`

## Requirements
- R1: After reset, both override bits, both enable bits, the slow-crystal disable bit (19) and the PLL2 enable bit (28) are 0. The crystal timer bit (20) and the PLL timer bit (29) are 1. The frequency word holds FREQ_RESET with its reserved bits masked. All ready flags are 0.
- R2: The crystal word is at offset 0x0C. Bit 0 is the main-crystal override and bit 1 is the main-crystal enable. The main crystal runs whenever bit 0 is 0, and also when bit 1 is 1. The new run state is visible in the cycle after the write.
- R3: The PLL word is at offset 0x10. Bit 0 is the PLL1 override and bit 1 is the PLL1 enable. PLL1 runs whenever bit 0 is 0, and also when bit 1 is 1.
- R4: Bit 28 of the PLL word switches PLL2 on when set and off when clear, whatever the value of any other bit.
- R5: Bit 19 of the crystal word set to 1 stops the slow crystal. Set to 0, it lets the slow crystal run.
- R6: With the group's timer bit at 1, a ready flag rises exactly XTAL_WAIT cycles (main crystal) or PLL_WAIT cycles (either PLL) after the source starts to run. The main-crystal flag is bit 2 of the crystal word. The PLL1 flag is bit 2 of the PLL word.
- R7: With the group's timer bit at 0, a ready flag rises in the cycle after the source starts to run.
- R8: A ready flag falls one cycle after its source stops. This holds even when the stop is written on the same edge at which the count completes: in that case the flag is high for exactly one cycle.
- R9: Bit 2 of the crystal word and bit 2 of the PLL word are read-only. A write to either bit changes neither the bit nor the ready output.
- R10: The frequency word is at offset 0x14. The PLL1 multiplier is bits 13:8 plus 2, the PLL1 post-shift is bits 2:0, and the PLL2 multiplier is bits 29:24 plus 2. These outputs change in the cycle after the write. All other bits of the word read as 0.
- R11: Any offset other than 0x0C, 0x10 and 0x14 reads as 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte offset of the access |
| writeEn | input | 1 | Write strobe |
| writeData | input | 32 | Write data |
| readData | output | 32 | Combinational read data for addr |
| mainXtalOn | output | 1 | Run request to the main crystal |
| slowXtalOn | output | 1 | Run request to the slow crystal |
| pll1On | output | 1 | Run request to PLL1 |
| pll2On | output | 1 | Run request to PLL2 |
| mainXtalReady | output | 1 | Main crystal start-up complete |
| pll1Ready | output | 1 | PLL1 locked |
| pll2Ready | output | 1 | PLL2 locked |
| pll1Mult | output | 7 | PLL1 multiplier (field plus 2) |
| pll1Shift | output | 3 | PLL1 output right shift |
| pll2Mult | output | 7 | PLL2 multiplier (field plus 2) |

## Verification
The ready timer finishing its count and a bus write that stops the same source can fall on one clock edge. The bench enables PLL1 with its override set. It waits until one cycle before the count ends, then writes the disable so that it lands on the completing edge. It expects the ready flag to be high for exactly one cycle while the run request is already low, and low from the next cycle on. A second coincidence is a write to a read-only ready bit in the same cycle that the ready bit is held or is falling. That case is judged by reading the word back and by watching the ready output.

// File: rtl/osc_pll_pkg.sv
package osc_pll_pkg;

  localparam int unsigned REG_W = 32;

  // byte offsets decoded by the block
  localparam int unsigned OFF_XTAL = 32'h0C;
  localparam int unsigned OFF_PLL  = 32'h10;
  localparam int unsigned OFF_FREQ = 32'h14;

  // crystal word fields
  localparam int unsigned XTAL_OVR_B  = 0;
  localparam int unsigned XTAL_EN_B   = 1;
  localparam int unsigned XTAL_STAT_B = 2;
  localparam int unsigned SLOW_DIS_B  = 19;
  localparam int unsigned XTAL_TIM_B  = 20;

  // pll control word fields
  localparam int unsigned PLL1_OVR_B  = 0;
  localparam int unsigned PLL1_EN_B   = 1;
  localparam int unsigned PLL1_STAT_B = 2;
  localparam int unsigned PLL2_EN_B   = 28;
  localparam int unsigned PLL_TIM_B   = 29;

  // frequency word fields
  localparam int unsigned SHIFT_LO = 0;
  localparam int unsigned SHIFT_HI = 2;
  localparam int unsigned M1_LO    = 8;
  localparam int unsigned M1_HI    = 13;
  localparam int unsigned M2_LO    = 24;
  localparam int unsigned M2_HI    = 29;

  localparam int unsigned NUM_SRC = 3;   // main crystal, pll1, pll2

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_XTAL,
    SEL_PLL,
    SEL_FREQ
  } rdSel_e;

  typedef struct packed {
    logic   wrXtal;
    logic   wrPll;
    logic   wrFreq;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/osc_pll_bus_decode.sv
module osc_pll_bus_decode
  import osc_pll_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeEn,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_XTAL = ADDR_W'(OFF_XTAL);
  localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(OFF_PLL);
  localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(OFF_FREQ);

  logic hitXtal, hitPll, hitFreq;

  always_comb begin
    hitXtal = (addr == A_XTAL);
    hitPll  = (addr == A_PLL);
    hitFreq = (addr == A_FREQ);
  end

  always_comb begin
    strobe.wrXtal = writeEn && hitXtal;
    strobe.wrPll  = writeEn && hitPll;
    strobe.wrFreq = writeEn && hitFreq;
    if (hitXtal)      strobe.rdSel = SEL_XTAL;
    else if (hitPll)  strobe.rdSel = SEL_PLL;
    else if (hitFreq) strobe.rdSel = SEL_FREQ;
    else              strobe.rdSel = SEL_NONE;
  end

  // at most one register is written per access (R11)
  assert_one_target_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrXtal, strobe.wrPll, strobe.wrFreq}));

  // an unmapped offset never produces a write strobe (R11)
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdSel == SEL_NONE) |-> !(strobe.wrXtal || strobe.wrPll || strobe.wrFreq));

endmodule

// File: rtl/osc_ready_timer.sv
module osc_ready_timer #(
  parameter int unsigned WAIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic timerOn,
  output logic ready
);

  localparam int unsigned CNT_W = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (!timerOn || cnt == LAST) ready <= 1'b1;
      else                         cnt   <= cnt + 1'b1;
    end
  end

  // a stopped source loses ready on the next edge (R8)
  assert_fall_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !ready);

  // ready only ever rises while the source was running (R6)
  assert_rise_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(run));

  // once ready, stays ready as long as the source keeps running (R6)
  assert_hold_while_run_R6: assert property (@(posedge clk) disable iff (rst)
    (ready && run) |=> ready);

endmodule

// File: rtl/osc_pll_datapath.sv
module osc_pll_datapath
  import osc_pll_pkg::*;
#(
  parameter int unsigned XTAL_WAIT  = 1000,
  parameter int unsigned PLL_WAIT   = 4000,
  parameter logic [31:0] FREQ_RESET = 32'h0A00_1401
) (
  input  logic             clk,
  input  logic             rst,
  input  busStrobe_t       strobe,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             mainXtalOn,
  output logic             slowXtalOn,
  output logic             pll1On,
  output logic             pll2On,
  output logic             mainXtalReady,
  output logic             pll1Ready,
  output logic             pll2Ready,
  output logic [6:0]       pll1Mult,
  output logic [2:0]       pll1Shift,
  output logic [6:0]       pll2Mult
);

  localparam int unsigned M_W = M1_HI - M1_LO + 1;
  localparam int unsigned S_W = SHIFT_HI - SHIFT_LO + 1;

  // crystal word storage
  logic xtalOvr, xtalEn, slowDis, xtalTimEn;
  // pll word storage
  logic pll1Ovr, pll1En, pll2En, pllTimEn;
  // frequency word storage
  logic [M_W-1:0] mult1Fld, mult2Fld;
  logic [S_W-1:0] shiftFld;

  always_ff @(posedge clk) begin
    if (rst) begin
      xtalOvr   <= 1'b0;
      xtalEn    <= 1'b0;
      slowDis   <= 1'b0;
      xtalTimEn <= 1'b1;
    end else if (strobe.wrXtal) begin
      xtalOvr   <= wdata[XTAL_OVR_B];
      xtalEn    <= wdata[XTAL_EN_B];
      slowDis   <= wdata[SLOW_DIS_B];
      xtalTimEn <= wdata[XTAL_TIM_B];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll1Ovr  <= 1'b0;
      pll1En   <= 1'b0;
      pll2En   <= 1'b0;
      pllTimEn <= 1'b1;
    end else if (strobe.wrPll) begin
      pll1Ovr  <= wdata[PLL1_OVR_B];
      pll1En   <= wdata[PLL1_EN_B];
      pll2En   <= wdata[PLL2_EN_B];
      pllTimEn <= wdata[PLL_TIM_B];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mult1Fld <= FREQ_RESET[M1_HI:M1_LO];
      mult2Fld <= FREQ_RESET[M2_HI:M2_LO];
      shiftFld <= FREQ_RESET[SHIFT_HI:SHIFT_LO];
    end else if (strobe.wrFreq) begin
      mult1Fld <= wdata[M1_HI:M1_LO];
      mult2Fld <= wdata[M2_HI:M2_LO];
      shiftFld <= wdata[SHIFT_HI:SHIFT_LO];
    end
  end

  // run requests: override clear means hardware keeps the source alive
  logic [NUM_SRC-1:0] srcRun, srcTim, srcReady;

  always_comb begin
    srcRun[0] = !xtalOvr || xtalEn;
    srcRun[1] = !pll1Ovr || pll1En;
    srcRun[2] = pll2En;
    srcTim[0] = xtalTimEn;
    srcTim[1] = pllTimEn;
    srcTim[2] = pllTimEn;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_timer
    localparam int unsigned W = (g == 0) ? XTAL_WAIT : PLL_WAIT;
    osc_ready_timer #(.WAIT(W)) i_timer (
      .clk     (clk),
      .rst     (rst),
      .run     (srcRun[g]),
      .timerOn (srcTim[g]),
      .ready   (srcReady[g])
    );
  end

  always_comb begin
    mainXtalOn    = srcRun[0];
    pll1On        = srcRun[1];
    pll2On        = srcRun[2];
    slowXtalOn    = !slowDis;
    mainXtalReady = srcReady[0];
    pll1Ready     = srcReady[1];
    pll2Ready     = srcReady[2];
    pll1Mult      = {1'b0, mult1Fld} + 7'd2;
    pll2Mult      = {1'b0, mult2Fld} + 7'd2;
    pll1Shift     = shiftFld;
  end

  always_comb begin
    rdata = '0;
    unique case (strobe.rdSel)
      SEL_XTAL: begin
        rdata[XTAL_OVR_B]  = xtalOvr;
        rdata[XTAL_EN_B]   = xtalEn;
        rdata[XTAL_STAT_B] = srcReady[0];
        rdata[SLOW_DIS_B]  = slowDis;
        rdata[XTAL_TIM_B]  = xtalTimEn;
      end
      SEL_PLL: begin
        rdata[PLL1_OVR_B]  = pll1Ovr;
        rdata[PLL1_EN_B]   = pll1En;
        rdata[PLL1_STAT_B] = srcReady[1];
        rdata[PLL2_EN_B]   = pll2En;
        rdata[PLL_TIM_B]   = pllTimEn;
      end
      SEL_FREQ: begin
        rdata[M1_HI:M1_LO]       = mult1Fld;
        rdata[M2_HI:M2_LO]       = mult2Fld;
        rdata[SHIFT_HI:SHIFT_LO] = shiftFld;
      end
      default: rdata = '0;
    endcase
  end

  // releasing the crystal override always leaves the crystal running (R2)
  assert_xtal_release_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrXtal && !wdata[XTAL_OVR_B]) |=> mainXtalOn);

  // with the override set, pll1 follows the written enable (R3)
  assert_pll1_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrPll && wdata[PLL1_OVR_B]) |=> (pll1On == $past(wdata[PLL1_EN_B])));

  // pll2 follows its enable bit directly (R4)
  assert_pll2_direct_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.wrPll |=> (pll2On == $past(wdata[PLL2_EN_B])));

  // decoded multiplier appears the cycle after a frequency write (R10)
  assert_mult_decode_R10: assert property (@(posedge clk) disable iff (rst)
    strobe.wrFreq |=> (pll1Mult == ({1'b0, $past(wdata[M1_HI:M1_LO])} + 7'd2)));

  // writes elsewhere leave the frequency outputs alone (R11)
  assert_freq_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrFreq |=> ($stable(pll1Mult) && $stable(pll2Mult) && $stable(pll1Shift)));

endmodule

// File: rtl/osc_pll_ctrl.sv
module osc_pll_ctrl
  import osc_pll_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned XTAL_WAIT  = 1000,
  parameter int unsigned PLL_WAIT   = 4000,
  parameter logic [31:0] FREQ_RESET = 32'h0A00_1401
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeEn,
  input  logic [31:0]       writeData,
  output logic [31:0]       readData,
  output logic              mainXtalOn,
  output logic              slowXtalOn,
  output logic              pll1On,
  output logic              pll2On,
  output logic              mainXtalReady,
  output logic              pll1Ready,
  output logic              pll2Ready,
  output logic [6:0]        pll1Mult,
  output logic [2:0]        pll1Shift,
  output logic [6:0]        pll2Mult
);

  busStrobe_t strobe;

  osc_pll_bus_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .writeEn (writeEn),
    .strobe  (strobe)
  );

  osc_pll_datapath #(
    .XTAL_WAIT  (XTAL_WAIT),
    .PLL_WAIT   (PLL_WAIT),
    .FREQ_RESET (FREQ_RESET)
  ) i_datapath (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .wdata         (writeData),
    .rdata         (readData),
    .mainXtalOn    (mainXtalOn),
    .slowXtalOn    (slowXtalOn),
    .pll1On        (pll1On),
    .pll2On        (pll2On),
    .mainXtalReady (mainXtalReady),
    .pll1Ready     (pll1Ready),
    .pll2Ready     (pll2Ready),
    .pll1Mult      (pll1Mult),
    .pll1Shift     (pll1Shift),
    .pll2Mult      (pll2Mult)
  );

endmodule

// File: tb/test_osc_pll_ctrl.sv
`timescale 1ns/1ps
module test_osc_pll_ctrl;

  localparam int unsigned XW = 5;
  localparam int unsigned PW = 9;
  localparam logic [31:0] FRST = 32'h0A00_1401;
  localparam logic [7:0] A_XTAL = 8'h0C, A_PLL = 8'h10, A_FREQ = 8'h14;
  localparam logic [31:0] TIMX = 32'h0010_0000, TIMP = 32'h2000_0000;
  localparam logic [31:0] SLOW = 32'h0008_0000, P2EN = 32'h1000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] addr = '0;
  logic writeEn = 1'b0;
  logic [31:0] writeData = '0, readData;
  logic mainXtalOn, slowXtalOn, pll1On, pll2On;
  logic mainXtalReady, pll1Ready, pll2Ready;
  logic [6:0] pll1Mult, pll2Mult;
  logic [2:0] pll1Shift;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc_pll_ctrl #(.ADDR_W(8), .XTAL_WAIT(XW), .PLL_WAIT(PW), .FREQ_RESET(FRST)) i_osc_pll_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .writeEn(writeEn), .writeData(writeData),
    .readData(readData), .mainXtalOn(mainXtalOn), .slowXtalOn(slowXtalOn),
    .pll1On(pll1On), .pll2On(pll2On), .mainXtalReady(mainXtalReady),
    .pll1Ready(pll1Ready), .pll2Ready(pll2Ready), .pll1Mult(pll1Mult),
    .pll1Shift(pll1Shift), .pll2Mult(pll2Mult));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; writeData = d; writeEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    writeEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; writeEn = 1'b0;
    #1 d = readData;
  endtask

  function automatic logic sel(input int which);
    case (which)
      0: return mainXtalReady;
      1: return pll1Ready;
      default: return pll2Ready;
    endcase
  endfunction

  // cycles from the last edge until the chosen ready flag is high
  task automatic pollRise(input int which, output int t);
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!sel(which) && t < 100);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [31:0] v;
    int tx, tp, t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_XTAL, v); chk("R1 xtal word", v, TIMX);
    rd(A_PLL, v);  chk("R1 pll word", v, TIMP);
    rd(A_FREQ, v); chk("R1 freq word", v, FRST);
    chk("R1 ready flags", {29'd0, mainXtalReady, pll1Ready, pll2Ready}, 32'd0);
    chk("R1 run requests", {28'd0, mainXtalOn, slowXtalOn, pll1On, pll2On}, 32'hE);
    chk("R1 pll1Mult", {25'd0, pll1Mult}, 32'd22);
    chk("R1 pll2Mult", {25'd0, pll2Mult}, 32'd12);
    chk("R1 pll1Shift", {29'd0, pll1Shift}, 32'd1);

    // R6 rise after reset, both sources counting together
    tx = 0; tp = 0; t = 0;
    while ((tx == 0 || tp == 0) && t < 100) begin
      @(negedge clk); t++;
      if (tx == 0 && mainXtalReady) tx = t;
      if (tp == 0 && pll1Ready) tp = t;
    end
    chk("R6 xtal start-up cycles", tx, XW);
    chk("R6 pll1 lock cycles", tp, PW);
    rd(A_XTAL, v); chk("R6 xtal status bit", v, TIMX | 32'h4);
    rd(A_PLL, v);  chk("R6 pll1 status bit", v, TIMP | 32'h4);

    // R2 override/enable sweep for the main crystal
    for (int o = 0; o < 2; o++) begin
      for (int e = 0; e < 2; e++) begin
        wr(A_XTAL, TIMX | 32'(o) | (32'(e) << 1));
        chk("R2 main crystal run", {31'd0, mainXtalOn}, {31'd0, (o == 0) || (e == 1)});
        rd(A_XTAL, v);
        chk("R2 crystal readback", v & 32'hFFFF_FFFB, TIMX | 32'(o) | (32'(e) << 1));
      end
    end

    // R3 override/enable sweep for pll1
    for (int o = 0; o < 2; o++) begin
      for (int e = 0; e < 2; e++) begin
        wr(A_PLL, TIMP | 32'(o) | (32'(e) << 1));
        chk("R3 pll1 run", {31'd0, pll1On}, {31'd0, (o == 0) || (e == 1)});
        chk("R4 pll2 stays off", {31'd0, pll2On}, 32'd0);
      end
    end

    // R5 slow crystal disable
    wr(A_XTAL, TIMX | SLOW | 32'h3);
    chk("R5 slow crystal stopped", {31'd0, slowXtalOn}, 32'd0);
    wr(A_XTAL, TIMX | 32'h3);
    chk("R5 slow crystal running", {31'd0, slowXtalOn}, 32'd1);

    // R4 + R6 pll2 direct enable and lock count
    wr(A_PLL, TIMP | P2EN);
    chk("R4 pll2 on", {31'd0, pll2On}, 32'd1);
    pollRise(2, t);
    chk("R6 pll2 lock cycles", t, PW);
    // R8 fall one cycle after stop
    wr(A_PLL, TIMP);
    chk("R4 pll2 off", {31'd0, pll2On}, 32'd0);
    chk("R8 pll2 ready lags stop", {31'd0, pll2Ready}, 32'd1);
    @(negedge clk);
    chk("R8 pll2 ready fell", {31'd0, pll2Ready}, 32'd0);

    // R7 bypassed timer on the main crystal
    wr(A_XTAL, 32'h1);
    repeat (2) @(negedge clk);
    chk("R7 xtal stopped first", {31'd0, mainXtalReady}, 32'd0);
    wr(A_XTAL, 32'h3);
    pollRise(0, t);
    chk("R7 one-cycle rise", t, 1);

    // R9 read-only status bit
    wr(A_XTAL, 32'h3);
    rd(A_XTAL, v); chk("R9 write 0 to status ignored", v, 32'h7);
    wr(A_XTAL, 32'h5);
    @(negedge clk);
    rd(A_XTAL, v); chk("R9 write 1 to status ignored", v, 32'h1);
    chk("R9 ready output low", {31'd0, mainXtalReady}, 32'd0);
    wr(A_PLL, TIMP | 32'h5);
    @(negedge clk);
    rd(A_PLL, v); chk("R9 pll status write ignored", v, TIMP | 32'h1);

    // R8 coincident stop on the completing edge
    wr(A_PLL, TIMP | 32'h3);
    repeat (PW - 1) @(negedge clk);
    chk("R8 pll1 not yet ready", {31'd0, pll1Ready}, 32'd0);
    wr(A_PLL, TIMP | 32'h1);
    chk("R8 pll1 stopped", {31'd0, pll1On}, 32'd0);
    chk("R8 pll1 one-cycle pulse", {31'd0, pll1Ready}, 32'd1);
    @(negedge clk);
    chk("R8 pll1 pulse ended", {31'd0, pll1Ready}, 32'd0);

    // R10 full sweep of the multiplier fields
    for (int m = 0; m < 64; m++) begin
      logic [31:0] d;
      d = 32'hC0C0_C0F8 | (32'(63 - m) << 24) | (32'(m) << 8) | 32'(m % 8);
      wr(A_FREQ, d);
      chk("R10 pll1Mult", {25'd0, pll1Mult}, 32'(m + 2));
      chk("R10 pll2Mult", {25'd0, pll2Mult}, 32'(65 - m));
      chk("R10 pll1Shift", {29'd0, pll1Shift}, 32'(m % 8));
      rd(A_FREQ, v);
      chk("R10 masked readback", v, d & 32'h3F00_3F07);
    end

    // R11 unmapped offsets
    rd(8'h00, v); chk("R11 read 0x00", v, 32'd0);
    rd(8'h18, v); chk("R11 read 0x18", v, 32'd0);
    rd(8'hFC, v); chk("R11 read 0xFC", v, 32'd0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    rd(A_XTAL, v); chk("R11 crystal untouched", v, 32'h1);
    rd(A_PLL, v);  chk("R11 pll untouched", v, TIMP | 32'h1);
    rd(A_FREQ, v); chk("R11 freq untouched", v, 32'h0000_3F07 & (32'hC0C0_C0F8 | (32'd0 << 24) | (32'd63 << 8) | 32'd7));

    done = 1'b1;
    summary();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

endmodule